// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a physical address by decoding a fixed map of address regions. Two kernel regions in the upper half of the space are direct windows: the physical address is the virtual address with a constant removed. The low half and the top quarter are page-mapped. For those regions the block sends a lookup to an external TLB and combines the returned hit, valid, dirty and frame number into a result. In kernel mode with the error-level flag set, the low half becomes a direct window instead, with a constant offset added.

Each request ends with a one-cycle pulse: either completion, with the physical address, or a fault, with an exception code. The code is chosen from the privilege check and the TLB result, and the access direction selects between the load and store variants. On a fault the block captures the whole faulting address in a bad-address register. It also writes the page-number bits of the faulting address into a context register and an entry-high register. Both keep their low 12 bits.

Top module: `seg_xlat`

## Requirements
- R1: After reset, done_o and fault_o are low, badvaddr_o is 0, context_o equals parameter CTX_RST and entryhi_o equals parameter EHI_RST.
- R2: With user_i=1, an address with bit 31 set faults one cycle after the request with exc_code_o 4 for a read (wr_i=0) or 5 for a write (wr_i=1), and issues no TLB lookup.
- R3: An address in 0x8000_0000..0x9FFF_FFFF completes one cycle after the request with paddr_o = vaddr - 0x8000_0000, without a TLB lookup.
- R4: An address in 0xA000_0000..0xBFFF_FFFF completes one cycle after the request with paddr_o = vaddr - 0xA000_0000, without a TLB lookup.
- R5: With user_i=0 and erl_i=1, an address below 0x8000_0000 completes one cycle after the request with paddr_o = vaddr + 0x4000_0000, without a TLB lookup.
- R6: An address below 0x8000_0000 (with user_i=1 or erl_i=0), or an address at or above 0xC000_0000 in kernel mode, raises tlb_req_o in the request cycle with tlb_vaddr_o = vaddr. The result appears one cycle after tlb_resp_i is seen.
- R7: A TLB response with hit, valid, and either a read or a dirty page completes with paddr_o = {tlb_pfn_i, vaddr[11:0]} and exc_code_o 0.
- R8: A TLB miss, or a hit on an invalid entry, faults with code 2 for a read and 3 for a write.
- R9: A write that hits a valid entry whose dirty bit is clear faults with code 1.
- R10: On every fault, badvaddr_o holds the full faulting address from the cycle fault_o is high.
- R11: On every fault, context_o[31:12] and entryhi_o[31:12] take vaddr[31:12] in the cycle fault_o is high, and their bits 11:0 keep their previous values.
- R12: Each request produces exactly one single-cycle pulse, on either done_o or fault_o and never both. Neither pulses while a TLB response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when idle |
| vaddr_i | input | 32 | Virtual address |
| wr_i | input | 1 | 1 = store, 0 = load |
| user_i | input | 1 | User privilege mode |
| erl_i | input | 1 | Error-level flag |
| tlb_req_o | output | 1 | TLB lookup request |
| tlb_vaddr_o | output | 32 | Address sent to the TLB |
| tlb_resp_i | input | 1 | TLB response valid |
| tlb_hit_i | input | 1 | Matching entry found |
| tlb_valid_i | input | 1 | Entry valid bit |
| tlb_dirty_i | input | 1 | Entry dirty (writable) bit |
| tlb_pfn_i | input | 20 | Page frame number |
| done_o | output | 1 | Translation completed pulse |
| fault_o | output | 1 | Fault pulse |
| exc_code_o | output | 5 | Exception code (0 on success) |
| paddr_o | output | 32 | Physical address |
| badvaddr_o | output | 32 | Last faulting address |
| context_o | output | 32 | Context register |
| entryhi_o | output | 32 | Entry-high register |

## Verification
A stuck or wrong FSM state shows at the ports within a cycle or two. Either a pulse appears while a TLB response is still pending, or no pulse follows a response. The bench watches for both in every mapped scenario, including lookups that wait several cycles. A wrong region decode or offset shows in the next cycle as a bad paddr_o, or as an unexpected tlb_req_o during the request cycle. Faults in the capture registers show in the same cycle as fault_o. They are compared at that point against a running model of all three registers, so a disturbed low field or a missed update is reported at the first fault that follows it.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned OFS_W = 12;
  localparam int unsigned PFN_W = AW - OFS_W;
  localparam int unsigned EC_W = 5;

  typedef enum logic [EC_W-1:0] {
    EXC_NONE = 5'd0,
    EXC_MOD  = 5'd1,
    EXC_TLBL = 5'd2,
    EXC_TLBS = 5'd3,
    EXC_ADEL = 5'd4,
    EXC_ADES = 5'd5
  } exc_e;

  typedef enum logic [1:0] {
    SEG_DIRECT = 2'd0,
    SEG_MAPPED = 2'd1,
    SEG_ADDRERR = 2'd2
  } seg_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;
endpackage

// File: rtl/seg_decode.sv
module seg_decode
  import seg_xlat_pkg::*;
#(
  parameter logic [AW-1:0] ERL_OFS = 32'h4000_0000
) (
  input  logic [AW-1:0] vaddr_i,
  input  logic          user_i,
  input  logic          erl_i,
  output seg_e          kind_o,
  output logic [AW-1:0] direct_pa_o
);
  always_comb begin
    kind_o      = SEG_MAPPED;
    direct_pa_o = vaddr_i;
    if (!vaddr_i[AW-1]) begin
      if (!user_i && erl_i) begin
        kind_o      = SEG_DIRECT;
        direct_pa_o = vaddr_i + ERL_OFS;
      end
    end else if (user_i) begin
      kind_o = SEG_ADDRERR;
    end else if (!vaddr_i[AW-2]) begin
      // both kernel windows strip the top three bits
      kind_o      = SEG_DIRECT;
      direct_pa_o = {3'b000, vaddr_i[AW-4:0]};
    end
  end
endmodule

// File: rtl/tlb_judge.sv
module tlb_judge
  import seg_xlat_pkg::*;
(
  input  logic             hit_i,
  input  logic             valid_i,
  input  logic             dirty_i,
  input  logic             wr_i,
  input  logic [PFN_W-1:0] pfn_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             ok_o,
  output exc_e             code_o,
  output logic [AW-1:0]    pa_o
);
  always_comb begin
    ok_o   = 1'b0;
    code_o = EXC_NONE;
    pa_o   = {pfn_i, ofs_i};
    if (!hit_i || !valid_i) code_o = wr_i ? EXC_TLBS : EXC_TLBL;
    else if (wr_i && !dirty_i) code_o = EXC_MOD;
    else ok_o = 1'b1;
  end
endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import seg_xlat_pkg::*;
#(
  parameter logic [AW-1:0] CTX_RST = 32'h0000_0A5C,
  parameter logic [AW-1:0] EHI_RST = 32'h0000_0033
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] va_i,
  output logic [AW-1:0] badvaddr_o,
  output logic [AW-1:0] context_o,
  output logic [AW-1:0] entryhi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      badvaddr_o <= '0;
      context_o  <= CTX_RST;
      entryhi_o  <= EHI_RST;
    end else if (we_i) begin
      badvaddr_o            <= va_i;
      context_o[AW-1:OFS_W] <= va_i[AW-1:OFS_W];
      entryhi_o[AW-1:OFS_W] <= va_i[AW-1:OFS_W];
    end
  end

  assert_bad_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> badvaddr_o == $past(va_i));
  assert_page_copy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (context_o[AW-1:OFS_W] == $past(va_i[AW-1:OFS_W]))
          && (entryhi_o[AW-1:OFS_W] == $past(va_i[AW-1:OFS_W])));
  assert_low_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> $stable(context_o[OFS_W-1:0]) && $stable(entryhi_o[OFS_W-1:0]));
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter logic [31:0] CTX_RST = 32'h0000_0A5C,
  parameter logic [31:0] EHI_RST = 32'h0000_0033,
  parameter logic [31:0] ERL_OFS = 32'h4000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [31:0] vaddr_i,
  input  logic        wr_i,
  input  logic        user_i,
  input  logic        erl_i,
  output logic        tlb_req_o,
  output logic [31:0] tlb_vaddr_o,
  input  logic        tlb_resp_i,
  input  logic        tlb_hit_i,
  input  logic        tlb_valid_i,
  input  logic        tlb_dirty_i,
  input  logic [19:0] tlb_pfn_i,
  output logic        done_o,
  output logic        fault_o,
  output logic [4:0]  exc_code_o,
  output logic [31:0] paddr_o,
  output logic [31:0] badvaddr_o,
  output logic [31:0] context_o,
  output logic [31:0] entryhi_o
);
  st_e           st_q, st_d;
  logic [AW-1:0] pend_va_q;
  logic          pend_wr_q;
  logic          done_d, fault_d;
  exc_e          code_q, code_d;
  logic [AW-1:0] pa_q, pa_d, fault_va;
  seg_e          kind;
  logic [AW-1:0] direct_pa, tlb_pa;
  logic          tlb_ok, accept;
  exc_e          tlb_code;

  seg_decode #(.ERL_OFS(ERL_OFS)) u_dec (
    .vaddr_i(vaddr_i), .user_i(user_i), .erl_i(erl_i),
    .kind_o(kind), .direct_pa_o(direct_pa)
  );

  tlb_judge u_judge (
    .hit_i(tlb_hit_i), .valid_i(tlb_valid_i), .dirty_i(tlb_dirty_i),
    .wr_i(pend_wr_q), .pfn_i(tlb_pfn_i), .ofs_i(pend_va_q[OFS_W-1:0]),
    .ok_o(tlb_ok), .code_o(tlb_code), .pa_o(tlb_pa)
  );

  assign accept      = req_i && (st_q == ST_IDLE);
  assign tlb_req_o   = accept && (kind == SEG_MAPPED);
  assign tlb_vaddr_o = vaddr_i;
  assign fault_va    = (st_q == ST_IDLE) ? vaddr_i : pend_va_q;

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    code_d  = code_q;
    pa_d    = pa_q;
    if (accept) begin
      unique case (kind)
        SEG_DIRECT: begin done_d = 1'b1; code_d = EXC_NONE; pa_d = direct_pa; end
        SEG_ADDRERR: begin fault_d = 1'b1; code_d = wr_i ? EXC_ADES : EXC_ADEL; end
        default: st_d = ST_WAIT;
      endcase
    end else if (st_q == ST_WAIT && tlb_resp_i) begin
      st_d    = ST_IDLE;
      done_d  = tlb_ok;
      fault_d = !tlb_ok;
      code_d  = tlb_code;
      if (tlb_ok) pa_d = tlb_pa;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pend_va_q <= '0;
      pend_wr_q <= 1'b0;
      done_o    <= 1'b0;
      fault_o   <= 1'b0;
      code_q    <= EXC_NONE;
      pa_q      <= '0;
    end else begin
      st_q    <= st_d;
      done_o  <= done_d;
      fault_o <= fault_d;
      code_q  <= code_d;
      pa_q    <= pa_d;
      if (accept) begin
        pend_va_q <= vaddr_i;
        pend_wr_q <= wr_i;
      end
    end
  end

  assign exc_code_o = code_q;
  assign paddr_o    = pa_q;

  fault_regs #(.CTX_RST(CTX_RST), .EHI_RST(EHI_RST)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(fault_d), .va_i(fault_va),
    .badvaddr_o(badvaddr_o), .context_o(context_o), .entryhi_o(entryhi_o)
  );

  assert_one_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  assert_wait_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !tlb_resp_i) |=> !(done_o || fault_o));
  assert_user_ade_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && user_i && vaddr_i[31]) |=>
      fault_o && (exc_code_o == EXC_ADEL || exc_code_o == EXC_ADES));
  assert_window_no_tlb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_req_o |-> (vaddr_i[31:30] != 2'b10));
  assert_done_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> exc_code_o == EXC_NONE);
endmodule

// File: tb/tb_seg_xlat.sv
module tb_seg_xlat;
  localparam logic [31:0] CTX0 = 32'h0000_0A5C;
  localparam logic [31:0] EHI0 = 32'h0000_0033;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, wr = 0, user = 0, erl = 0;
  logic [31:0] va = '0;
  logic tlb_resp = 0, tlb_hit = 0, tlb_valid = 0, tlb_dirty = 0;
  logic [19:0] tlb_pfn = '0;
  logic tlb_req, done, fault;
  logic [31:0] tlb_va, pa, bad, ctx, ehi;
  logic [4:0] code;
  int checks = 0, errors = 0;
  logic [31:0] exp_bad = '0, exp_ctx = CTX0, exp_ehi = EHI0;
  bit finished = 0;

  always #10 clk = ~clk;

  seg_xlat #(.CTX_RST(CTX0), .EHI_RST(EHI0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(va), .wr_i(wr),
    .user_i(user), .erl_i(erl), .tlb_req_o(tlb_req), .tlb_vaddr_o(tlb_va),
    .tlb_resp_i(tlb_resp), .tlb_hit_i(tlb_hit), .tlb_valid_i(tlb_valid),
    .tlb_dirty_i(tlb_dirty), .tlb_pfn_i(tlb_pfn), .done_o(done),
    .fault_o(fault), .exc_code_o(code), .paddr_o(pa), .badvaddr_o(bad),
    .context_o(ctx), .entryhi_o(ehi)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(bad == exp_bad, {tag, " R10 badvaddr"}, bad, exp_bad);
    chk(ctx == exp_ctx, {tag, " R11 context"}, ctx, exp_ctx);
    chk(ehi == exp_ehi, {tag, " R11 entryhi"}, ehi, exp_ehi);
  endtask

  task automatic note_fault(input logic [31:0] a);
    exp_bad = a;
    exp_ctx = {a[31:12], exp_ctx[11:0]};
    exp_ehi = {a[31:12], exp_ehi[11:0]};
  endtask

  task automatic issue(input logic [31:0] a, input bit w, input bit u, input bit e, input bit exp_tlb);
    @(negedge clk);
    va = a; wr = w; user = u; erl = e; req = 1;
    #1 chk(tlb_req == exp_tlb, "R6 tlb_req in request cycle", 32'(tlb_req), 32'(exp_tlb));
    if (exp_tlb) chk(tlb_va == a, "R6 tlb_vaddr", tlb_va, a);
    @(posedge clk); #1 req = 0;
  endtask

  task automatic pulse_gone(input string tag);
    @(posedge clk); #1;
    chk(!done && !fault, {tag, " R12 single pulse"}, {30'd0, done, fault}, 0);
  endtask

  task automatic t_direct(input logic [31:0] a, input bit w, input bit u, input bit e,
                          input logic [31:0] exp_pa, input string tag);
    issue(a, w, u, e, 1'b0);
    chk(done && !fault, {tag, " done"}, {30'd0, done, fault}, 32'd2);
    chk(pa == exp_pa, {tag, " paddr"}, pa, exp_pa);
    chk(code == 5'd0, {tag, " code"}, 32'(code), 0);
    chk_regs(tag);
    pulse_gone(tag);
  endtask

  task automatic t_ade(input logic [31:0] a, input bit w);
    issue(a, w, 1'b1, 1'b0, 1'b0);
    note_fault(a);
    chk(fault && !done, "R2 fault pulse", {30'd0, done, fault}, 32'd1);
    chk(code == (w ? 5'd5 : 5'd4), "R2 code", 32'(code), w ? 5 : 4);
    chk_regs("R2");
    pulse_gone("R2");
  endtask

  task automatic t_tlb(input logic [31:0] a, input bit w, input bit u, input bit e, input int wait_cyc,
                       input bit h, input bit v, input bit d, input logic [19:0] pfn,
                       input logic [4:0] exp_code, input string tag);
    issue(a, w, u, e, 1'b1);
    for (int i = 0; i < wait_cyc; i++) begin
      chk(!done && !fault, {tag, " R12 quiet while pending"}, {30'd0, done, fault}, 0);
      @(posedge clk); #1;
    end
    chk(!done && !fault, {tag, " R12 quiet while pending"}, {30'd0, done, fault}, 0);
    tlb_resp = 1; tlb_hit = h; tlb_valid = v; tlb_dirty = d; tlb_pfn = pfn;
    @(posedge clk); #1;
    tlb_resp = 0; tlb_pfn = 20'h0;
    chk(code == exp_code, {tag, " code"}, 32'(code), 32'(exp_code));
    if (exp_code == 5'd0) begin
      chk(done && !fault, {tag, " R7 done"}, {30'd0, done, fault}, 32'd2);
      chk(pa == {pfn, a[11:0]}, {tag, " R7 paddr"}, pa, {pfn, a[11:0]});
    end else begin
      note_fault(a);
      chk(fault && !done, {tag, " fault"}, {30'd0, done, fault}, 32'd1);
    end
    chk_regs(tag);
    pulse_gone(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!done && !fault, "R1 strobes low", {30'd0, done, fault}, 0);
    chk_regs("R1");
    @(negedge clk) rst_n = 1;
    t_direct(32'h8000_0000, 0, 0, 0, 32'h0000_0000, "R3 low edge");
    t_direct(32'h9FFF_FFFC, 1, 0, 0, 32'h1FFF_FFFC, "R3 high edge");
    t_direct(32'hA000_0010, 0, 0, 1, 32'h0000_0010, "R4 low");
    t_direct(32'hBFFF_F000, 1, 0, 0, 32'h1FFF_F000, "R4 high edge");
    t_direct(32'h0012_3456, 0, 0, 1, 32'h4012_3456, "R5 erl");
    t_direct(32'h7FFF_FFFF, 1, 0, 1, 32'hBFFF_FFFF, "R5 top");
    t_ade(32'h8000_0000, 0);
    t_ade(32'hFFFF_F123, 1);
    t_tlb(32'h0040_1ABC, 0, 1, 0, 0, 1, 1, 0, 20'h12345, 5'd0, "R7 user read");
    t_tlb(32'h0040_2ABC, 1, 1, 1, 2, 1, 1, 1, 20'h0ABCD, 5'd0, "R7 user erl write dirty");
    t_tlb(32'hC000_0FFF, 0, 0, 0, 1, 1, 1, 1, 20'hFFFFF, 5'd0, "R6 kseg2 read");
    t_tlb(32'h1234_5678, 0, 0, 0, 3, 0, 0, 0, 20'h00000, 5'd2, "R8 miss load");
    t_tlb(32'hE000_1000, 1, 0, 0, 0, 0, 1, 1, 20'h00001, 5'd3, "R8 miss store");
    t_tlb(32'h0800_0123, 0, 1, 0, 0, 1, 0, 1, 20'h00002, 5'd2, "R8 invalid load");
    t_tlb(32'hF00D_0F00, 1, 0, 0, 1, 1, 0, 1, 20'h00003, 5'd3, "R8 invalid store");
    t_tlb(32'h0ABC_DEF0, 1, 0, 0, 0, 1, 1, 0, 20'h00004, 5'd1, "R9 clean write");
    t_tlb(32'hDEAD_B000, 0, 0, 0, 0, 1, 1, 0, 20'h55555, 5'd0, "R9 clean read ok");
    t_direct(32'h8765_4321, 0, 0, 0, 32'h0765_4321, "R11 regs held after done");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule